// File: doc/BRIEF.md
# Ring-Oscillation Boundary Wrapper Segment

This block is a segment of core-boundary wrapper cells: a row of input-pin cells followed by a row of output-pin cells, all linked into one scan path. In the ordinary setting each cell behaves as a conventional wrapper cell. It passes functional signals through, captures pin or core values, shifts them along the scan path, and drives update values into the core or onto the pin in test mode.

When the global ring-test control is raised, each cell switches to a purely combinational path so that interconnect wires and scan links can be closed into an oscillating loop. An input cell either forwards its pin value onto the scan link or passes the incoming scan link straight through. The choice comes from a dedicated select flop in the scan path. An output cell sends the incoming scan link to both its scan output and its pin. Its update bit decides whether that signal is complemented.

All configuration is shifted in and updated before a ring session starts. While the ring control is high, all storage is frozen, so the configuration cannot drift during a measurement.

Top module: `owr_segment`

## Requirements
- R1: Synchronous active-low reset clears every data, select and update flop to 0. After reset with ring mode off, `scan_out` is 0, and in test mode `core_in` and `pin_out` are 0.
- R2: With `ring_mode`=0 and `test_mode`=0, `core_in` equals `pin_in` and `pin_out` equals `core_out`, combinationally.
- R3: With `ring_mode`=0 and `shift_en`=1, each clock moves the scan path by one position. Path order from `scan_in`: for each input cell k = 0..N_IN-1, its data flop then its select flop; then, for each output cell k = 0..N_OUT-1, its data flop. `scan_out` is the last flop, so the path is 2·N_IN+N_OUT long.
- R4: With `ring_mode`=0, `shift_en`=0 and `capture_en`=1, input-cell data flops load `pin_in` and output-cell data flops load `core_out`. Select flops keep their value.
- R5: With `ring_mode`=0 and `update_en`=1, every update flop loads its cell's data flop value from before the edge. With `test_mode`=1, `core_in` shows the input update flops and `pin_out` shows the output update flops.
- R6: With `ring_mode`=1, an input cell whose select flop is 1 drives its scan output with its `pin_in` bit.
- R7: With `ring_mode`=1, an input cell whose select flop is 0 passes its scan input to its scan output unchanged, so `scan_out` is the combinational result of the whole segment.
- R8: With `ring_mode`=1, an output cell drives the same value on its scan output and its `pin_out` bit. That value is the scan input when the cell's update flop is 1 and its complement when the update flop is 0.
- R9: While `ring_mode`=1, no flop changes on any clock edge, whatever `shift_en`, `capture_en` and `update_en` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan/test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_mode | input | 1 | Global ring-oscillation test control |
| test_mode | input | 1 | Wrapper test mode: update flops drive core/pin |
| shift_en | input | 1 | Shift the scan path |
| capture_en | input | 1 | Capture pin/core values into data flops |
| update_en | input | 1 | Copy data flops into update flops |
| scan_in | input | 1 | Scan path input |
| scan_out | output | 1 | Scan path output |
| pin_in | input | N_IN | Input pins from the interconnect |
| core_in | output | N_IN | Signals into the core |
| core_out | input | N_OUT | Signals from the core |
| pin_out | output | N_OUT | Output pins to the interconnect |

## Verification
The embedded assertions check cycle by cycle that ring mode freezes the select and inversion storage, that shift and capture move the expected bits one edge later, and that an output cell's scan and pin outputs agree in ring mode. The composed combinational path through the whole segment can only be shown by the bench's scenarios. Those scenarios cover each select and inversion combination, captured values made visible by shifting out, and a ring burst with all strobes high followed by a full unload.

// File: rtl/owr_pkg.sv
// Shared definitions for the ring-oscillation wrapper segment.
// Assumes all controls are synchronous to the scan clock.
package owr_pkg;
    typedef struct packed {
        logic ring_mode;
        logic test_mode;
        logic shift_en;
        logic capture_en;
        logic update_en;
    } owr_ctrl_t;
endpackage

// File: rtl/owr_mux2.sv
// Plain 2:1 multiplexer used for every path choice in the cells.
// Assumes nothing; purely combinational.
module owr_mux2 #(
    parameter int W = 1
) (
    input  logic         pick,
    input  logic [W-1:0] a0,
    input  logic [W-1:0] a1,
    output logic [W-1:0] y
);
    // select between the two inputs
    always_comb y = pick ? a1 : a0;
endmodule

// File: rtl/owr_in_cell.sv
// Input-pin wrapper cell with a ring-oscillation bypass.
// Scan order inside the cell: si -> data_q -> sel_q -> so.
// In ring mode, sel_q chooses pin_in (1) or si (0) for so; storage is frozen.
// Assumes ring mode is entered only after sel_q was loaded by shifting.
module owr_in_cell
    import owr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  owr_ctrl_t ctrl,
    input  logic      si,
    input  logic      pin_in,
    output logic      so,
    output logic      core_in
);
    logic data_q;
    logic sel_q;
    logic upd_q;
    logic ring_bit;
    logic live;

    assign live = !ctrl.ring_mode;

    // scan, capture and select storage; frozen while ring mode is on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 1'b0;
            sel_q  <= 1'b0;
        end else if (live) begin
            if (ctrl.shift_en) begin
                data_q <= si;
                sel_q  <= data_q;
            end else if (ctrl.capture_en) begin
                data_q <= pin_in;
            end
        end
    end

    // update stage feeding the core in test mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= 1'b0;
        else if (live && ctrl.update_en)
            upd_q <= data_q;
    end

    // first added mux: pin or scan input onto the ring
    owr_mux2 #(.W(1)) u_ring_src (
        .pick (sel_q),
        .a0   (si),
        .a1   (pin_in),
        .y    (ring_bit)
    );

    // second added mux: normal scan output or ring path
    owr_mux2 #(.W(1)) u_so_mode (
        .pick (ctrl.ring_mode),
        .a0   (sel_q),
        .a1   (ring_bit),
        .y    (so)
    );

    // normal cell core-side mux
    owr_mux2 #(.W(1)) u_core_drv (
        .pick (ctrl.test_mode),
        .a0   (pin_in),
        .a1   (upd_q),
        .y    (core_in)
    );

    AST_IN_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ring_mode |=> $stable(sel_q) && $stable(data_q) && $stable(upd_q)); // R9
    AST_IN_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ctrl.shift_en) |=> (sel_q == $past(data_q)) && (data_q == $past(si))); // R3
    AST_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !ctrl.shift_en && ctrl.capture_en) |=> (data_q == $past(pin_in)) && $stable(sel_q)); // R4
    AST_IN_RING_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.ring_mode && sel_q) |-> (so == pin_in)); // R6
endmodule

// File: rtl/owr_out_cell.sv
// Output-pin wrapper cell with a ring-oscillation bypass.
// Scan order inside the cell: si -> data_q -> so.
// In ring mode, si (kept when upd_q=1, complemented when upd_q=0) drives both
// so and pin_out; storage is frozen. Assumes upd_q was set before the session.
module owr_out_cell
    import owr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  owr_ctrl_t ctrl,
    input  logic      si,
    input  logic      core_out,
    output logic      so,
    output logic      pin_out
);
    logic data_q;
    logic upd_q;
    logic ring_bit;
    logic norm_pin;
    logic live;
    logic si_n;

    assign live = !ctrl.ring_mode;
    assign si_n = ~si;

    // scan and capture storage; frozen while ring mode is on
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= 1'b0;
        else if (live) begin
            if (ctrl.shift_en)
                data_q <= si;
            else if (ctrl.capture_en)
                data_q <= core_out;
        end
    end

    // update stage: pin value in test mode, inversion control in ring mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= 1'b0;
        else if (live && ctrl.update_en)
            upd_q <= data_q;
    end

    // first added mux: true or complemented scan input
    owr_mux2 #(.W(1)) u_polarity (
        .pick (upd_q),
        .a0   (si_n),
        .a1   (si),
        .y    (ring_bit)
    );

    // normal cell pin-side mux
    owr_mux2 #(.W(1)) u_pin_norm (
        .pick (ctrl.test_mode),
        .a0   (core_out),
        .a1   (upd_q),
        .y    (norm_pin)
    );

    // second added mux: normal or ring value on both pin and scan output
    owr_mux2 #(.W(2)) u_ring_sel (
        .pick (ctrl.ring_mode),
        .a0   ({norm_pin, data_q}),
        .a1   ({ring_bit, ring_bit}),
        .y    ({pin_out, so})
    );

    AST_OUT_INV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ring_mode |=> $stable(upd_q) && $stable(data_q)); // R9
    AST_OUT_RING_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ring_mode |-> (pin_out == so)); // R8
    AST_OUT_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ctrl.shift_en) |=> (data_q == $past(si))); // R3
    AST_OUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ctrl.update_en) |=> (upd_q == $past(data_q))); // R5
endmodule

// File: rtl/owr_segment.sv
// Segment of boundary wrapper cells: N_IN input cells then N_OUT output cells
// on one scan path. Normal wrapper behaviour when ring_mode=0; combinational
// ring-oscillation paths when ring_mode=1. Assumes synchronous controls.
module owr_segment
    import owr_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_mode,
    input  logic             test_mode,
    input  logic             shift_en,
    input  logic             capture_en,
    input  logic             update_en,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pin_out
);
    localparam int N_CELLS = N_IN + N_OUT;

    owr_ctrl_t           ctrl;
    logic [N_CELLS:0]    link;

    // bundle controls for the cells
    always_comb begin
        ctrl.ring_mode  = ring_mode;
        ctrl.test_mode  = test_mode;
        ctrl.shift_en   = shift_en;
        ctrl.capture_en = capture_en;
        ctrl.update_en  = update_en;
    end

    assign link[0]  = scan_in;
    assign scan_out = link[N_CELLS];

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        owr_in_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl    (ctrl),
            .si      (link[gi]),
            .pin_in  (pin_in[gi]),
            .so      (link[gi+1]),
            .core_in (core_in[gi])
        );
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_out
        owr_out_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl     (ctrl),
            .si       (link[N_IN+go]),
            .core_out (core_out[go]),
            .so       (link[N_IN+go+1]),
            .pin_out  (pin_out[go])
        );
    end

    AST_SEG_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_mode && !test_mode) |-> (core_in == pin_in) && (pin_out == core_out)); // R2
endmodule

// File: tb/test_owr_segment.sv
`timescale 1ns/1ps
module test_owr_segment;
    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int L     = 2*N_IN + N_OUT;

    logic clk = 1'b0;
    logic rst_n;
    logic r_ring, r_test, r_shift, r_cap, r_upd, r_si;
    logic [N_IN-1:0]  r_pin;
    logic [N_OUT-1:0] r_core;
    logic             scan_out;
    logic [N_IN-1:0]  core_in;
    logic [N_OUT-1:0] pin_out;

    logic [L-1:0]     m_chain;
    logic [N_IN-1:0]  m_upd_in;
    logic [N_OUT-1:0] m_upd_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    owr_segment #(.N_IN(N_IN), .N_OUT(N_OUT)) i_owr_segment (
        .clk(clk), .rst_n(rst_n), .ring_mode(r_ring), .test_mode(r_test),
        .shift_en(r_shift), .capture_en(r_cap), .update_en(r_upd),
        .scan_in(r_si), .scan_out(scan_out), .pin_in(r_pin), .core_in(core_in),
        .core_out(r_core), .pin_out(pin_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs against the requirement model
    task automatic check_outputs(string so_tag);
        logic v;
        logic [N_IN-1:0]  e_core;
        logic [N_OUT-1:0] e_pin;
        logic             e_so;
        v = r_si;
        for (int i = 0; i < N_IN; i++) begin
            if (m_chain[2*i+1]) v = r_pin[i];
            e_core[i] = r_test ? m_upd_in[i] : r_pin[i];
        end
        for (int j = 0; j < N_OUT; j++) begin
            if (!m_upd_out[j]) v = ~v;
            e_pin[j] = r_ring ? v : (r_test ? m_upd_out[j] : r_core[j]);
        end
        e_so = r_ring ? v : m_chain[L-1];
        chk(r_ring ? "R7 scan_out ring path" : so_tag, 32'(scan_out), 32'(e_so));
        chk(r_ring ? "R8 pin_out ring" : (r_test ? "R5 pin_out test" : "R2 pin_out func"),
            32'(pin_out), 32'(e_pin));
        chk(r_test ? "R5 core_in test" : "R2 core_in func", 32'(core_in), 32'(e_core));
    endtask

    // model state change at a clock edge
    task automatic model_edge();
        if (!r_ring) begin
            if (r_upd) begin
                for (int i = 0; i < N_IN; i++)  m_upd_in[i]  = m_chain[2*i];
                for (int j = 0; j < N_OUT; j++) m_upd_out[j] = m_chain[2*N_IN+j];
            end
            if (r_shift)
                m_chain = {m_chain[L-2:0], r_si};
            else if (r_cap) begin
                for (int i = 0; i < N_IN; i++)  m_chain[2*i] = r_pin[i];
                for (int j = 0; j < N_OUT; j++) m_chain[2*N_IN+j] = r_core[j];
            end
        end
    endtask

    // one cycle: inputs already set at negedge; check, clock, model
    task automatic cyc(string so_tag);
        #1;
        check_outputs(so_tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        r_ring = 0; r_shift = 0; r_cap = 0; r_upd = 0;
    endtask

    // shift a full configuration in (bit L-1 first), then update
    task automatic load_cfg(logic [L-1:0] cfg);
        idle();
        r_test = 0;
        for (int k = L-1; k >= 0; k--) begin
            r_shift = 1; r_si = cfg[k];
            cyc("R3 shift");
        end
        r_shift = 0; r_upd = 1;
        cyc("R3 shift");
        r_upd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] cfg;
        void'($urandom(32'd1234));
        rst_n = 0; idle(); r_test = 0; r_si = 0; r_pin = '0; r_core = '0;
        m_chain = '0; m_upd_in = '0; m_upd_out = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        chk("R1 scan_out after reset", 32'(scan_out), 32'd0);
        r_test = 1; #1;
        chk("R1 core_in test after reset", 32'(core_in), 32'd0);
        chk("R1 pin_out test after reset", 32'(pin_out), 32'd0);
        r_test = 0;
        @(negedge clk);

        // R2: functional pass-through patterns
        for (int k = 0; k < 8; k++) begin
            r_pin = N_IN'($urandom); r_core = N_OUT'($urandom);
            cyc("R2 scan_out idle");
        end

        // R4: capture then unload
        r_pin = 4'b1010; r_core = 4'b0110; r_cap = 1;
        cyc("R4 capture");
        r_cap = 0;
        for (int k = 0; k < L; k++) begin
            r_shift = 1; r_si = 1'b0;
            cyc("R4 captured bits unload");
        end
        r_shift = 0;

        // R6/R7/R8: directed select/inversion combinations
        for (int p = 0; p < 6; p++) begin
            cfg = L'($urandom);
            if (p == 0) cfg = '0;
            if (p == 1) cfg = '1;
            load_cfg(cfg);
            r_ring = 1;
            for (int s = 0; s < 2*(1 << N_IN); s++) begin
                r_si = s[0]; r_pin = N_IN'(s >> 1); r_core = N_OUT'($urandom);
                r_test = s[1];
                cyc("R6 ring");
            end
            r_ring = 0;
        end

        // R9: ring burst with all strobes high, then full unload
        load_cfg(L'($urandom));
        r_ring = 1; r_shift = 1; r_cap = 1; r_upd = 1;
        for (int k = 0; k < 6; k++) begin
            r_si = k[0]; r_pin = N_IN'($urandom); r_core = N_OUT'($urandom);
            cyc("R9 ring burst");
        end
        idle(); r_test = 1;
        cyc("R9 update held");
        for (int k = 0; k < L; k++) begin
            r_shift = 1; r_si = 1'b1;
            cyc("R9 state held after ring");
        end

        // random mix
        for (int k = 0; k < 1500; k++) begin
            r_ring  = ($urandom % 5) == 0;
            r_test  = $urandom;
            r_shift = $urandom;
            r_cap   = $urandom;
            r_upd   = ($urandom % 4) == 0;
            r_si    = $urandom;
            r_pin   = N_IN'($urandom);
            r_core  = N_OUT'($urandom);
            cyc(r_shift ? "R3 random shift" : (r_cap ? "R4 random capture" : "R3 random hold"));
        end

        // reset in mid-run
        rst_n = 0; idle();
        @(posedge clk); m_chain = '0; m_upd_in = '0; m_upd_out = '0;
        @(negedge clk); rst_n = 1;
        cyc("R1 scan_out after second reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule